// File: doc/BRIEF.md
# UART Receive Character Queue

This block sits between a UART receive deserializer and the host. When the deserializer has a finished character in its shift register (stop bit seen), it raises `chr_valid` and keeps the character, with its parity-error and framing-error flags, steady until `chr_take` pulses. Accepted characters are kept in a small first-in first-out buffer. The host sees the oldest one on `rd_data`/`rd_perr`/`rd_ferr` and pops it with `rd_en`.

The host is told that data is waiting through `rx_avail` and a one-cycle `rx_irq` pulse. A 2-bit `irq_mode` input sets the fill level at which the pulse fires. If a character finishes while the buffer is full, the block latches `rx_ovr` and raises `chr_hold`. The deserializer then freezes with its character intact until software pulses `ovr_clr`. Buffer depth and character width are parameters.

Top module: `uart_rx_fifo`

## Requirements
- R1: The buffer stores DEPTH (default 4) characters. A further finished character stays in the shift register and is not taken, so DEPTH+1 characters can be pending.
- R2: With `irq_mode` 00 or 01, `rx_irq` is high for exactly one cycle, the cycle after each transfer (`chr_take` high).
- R3: With `irq_mode` 10, the pulse fires only for a transfer that leaves exactly DEPTH-1 characters in the buffer, counting a read popped in the same cycle.
- R4: With `irq_mode` 11, the pulse fires only for a transfer that leaves the buffer full (DEPTH characters).
- R5: `rx_avail` is 1 exactly when the buffer holds at least one character. It is updated at the clock edge that changes the fill level.
- R6: `rd_en` while the buffer is empty changes neither the fill level nor `rd_data`, `rd_perr` or `rd_ferr`.
- R7: Characters leave in arrival order. The data bits and both error flags of the head character are on the read outputs. After the last character is popped, that character stays on the outputs.
- R8: `rx_ovr` is set at the edge after a cycle in which `chr_valid` is high and the buffer is full. A read in that same cycle does not prevent it.
- R9: While `rx_ovr` is 1, `chr_hold` is 1 and `chr_take` is 0, even if reads free space. The stored characters are preserved and come out intact.
- R10: `rx_ovr` clears only on an `ovr_clr` pulse (which wins over a new set) or on reset. Reset also empties the buffer and zeroes the read outputs and `rx_irq`.
- R11: `chr_take` is high in the same cycle as `chr_valid` whenever the buffer has room and `rx_ovr` is 0. After a clear, a waiting character is therefore taken in the cycle after `ovr_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_valid | input | 1 | Shift register holds a finished character |
| chr_data | input | DATA_W | Character data bits |
| chr_perr | input | 1 | Parity error of the character |
| chr_ferr | input | 1 | Framing error of the character |
| chr_take | output | 1 | Character moved into the buffer this cycle |
| chr_hold | output | 1 | Deserializer must not shift in new bits |
| irq_mode | input | 2 | Interrupt fill-level select |
| rd_en | input | 1 | Pop the head character |
| rd_data | output | DATA_W | Head character data |
| rd_perr | output | 1 | Head character parity error |
| rd_ferr | output | 1 | Head character framing error |
| rx_avail | output | 1 | Buffer non-empty |
| rx_ovr | output | 1 | Overrun latched |
| ovr_clr | input | 1 | Software overrun clear pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench targets the cycle where a transfer and a read coincide. A design that used the level before the read would fire the mode-10 and mode-11 pulses one character late or never. It fills the buffer and leaves a fifth character waiting, then drains. A design that kept taking after the overrun, or dropped or reordered the held characters, shows wrong data on the read port. It reads an empty buffer, which exposes head registers that drift or pointers that move. It also clears the overrun with a character still waiting, to check the transfer in the next cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    IRQ_EVERY_A = 2'b00,
    IRQ_EVERY_B = 2'b01,
    IRQ_NEAR    = 2'b10,
    IRQ_FULL    = 2'b11
  } irq_sel_e;

  // True when a transfer that results in fill level 'fill' should interrupt.
  function automatic logic irq_hit(input irq_sel_e sel, input int fill, input int depth);
    case (sel)
      IRQ_NEAR: return fill == depth - 1;
      IRQ_FULL: return fill == depth;
      default:  return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 4,
  parameter int W     = 11,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [CW-1:0] count,
  output logic [CW-1:0] fill_nxt,
  output logic [W-1:0]  head
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_nxt, wr_nxt;

  assign rd_nxt   = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
  assign wr_nxt   = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
  assign fill_nxt = count + CW'(push) - CW'(pop);

  // Plain write port, no reset: maps onto inferred RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      count <= fill_nxt;
    end
  end

  // Registered head: follows the oldest entry, holds its value once empty.
  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
    end else if (push && (count == '0 || (count == CW'(1) && pop))) begin
      head <= wdata;
    end else if (pop && count > CW'(1)) begin
      head <= mem[rd_nxt];
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CW'(DEPTH)));

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));

endmodule

// File: rtl/rxq_ovr.sv
module rxq_ovr (
  input  logic clk,
  input  logic rst,
  input  logic chr_valid,
  input  logic full,
  input  logic clr,
  output logic take,
  output logic ovr
);

  assign take = chr_valid && !full && !ovr;

  always_ff @(posedge clk) begin
    if (rst) ovr <= 1'b0;
    else     ovr <= !clr && (ovr || (chr_valid && full));
  end

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ovr && !clr) |=> ovr);

  p_ovr_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> !ovr);

  p_ovr_set_r8: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && full && !clr) |=> ovr);

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] fill_nxt,
  output logic          irq
);
  import rxq_pkg::*;

  irq_sel_e sel;
  assign sel = irq_sel_e'(mode);

  // The mode is sampled only in the cycle a transfer happens.
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= take && irq_hit(sel, int'(fill_nxt), DEPTH);
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 9,
  localparam int EW    = DATA_W + 2,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chr_valid,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              chr_perr,
  input  logic              chr_ferr,
  output logic              chr_take,
  output logic              chr_hold,
  input  logic [1:0]        irq_mode,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              rx_avail,
  output logic              rx_ovr,
  input  logic              ovr_clr,
  output logic              rx_irq
);

  logic [CW-1:0] count, fill_nxt;
  logic [EW-1:0] head;
  logic          full, pop, avail_q;

  assign full = (count == CW'(DEPTH));
  assign pop  = rd_en && (count != '0);

  rxq_ovr u_ovr (
    .clk       (clk),
    .rst       (rst),
    .chr_valid (chr_valid),
    .full      (full),
    .clr       (ovr_clr),
    .take      (chr_take),
    .ovr       (rx_ovr)
  );

  rxq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .push     (chr_take),
    .pop      (pop),
    .wdata    ({chr_perr, chr_ferr, chr_data}),
    .count    (count),
    .fill_nxt (fill_nxt),
    .head     (head)
  );

  rxq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .take     (chr_take),
    .mode     (irq_mode),
    .fill_nxt (fill_nxt),
    .irq      (rx_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) avail_q <= 1'b0;
    else     avail_q <= (fill_nxt != '0);
  end

  assign rx_avail = avail_q;
  assign chr_hold = rx_ovr;
  assign rd_perr  = head[EW-1];
  assign rd_ferr  = head[EW-2];
  assign rd_data  = head[DATA_W-1:0];

  p_avail_level_r5: assert property (@(posedge clk) disable iff (rst)
    rx_avail == (count != '0));

  p_irq_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(chr_take));

  p_near_level_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && $past(irq_mode) == 2'b10) |-> (count == CW'(DEPTH - 1)));

  p_full_level_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && $past(irq_mode) == 2'b11) |-> full);

  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_ovr && !rd_en) |=> $stable(count));

  p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rx_avail && !chr_take) |=> $stable(head));

endmodule

// File: tb/test_uart_rx_fifo.sv
module test_uart_rx_fifo;
  localparam int DEPTH = 4;
  localparam int DW    = 9;

  logic          clk = 1'b0;
  logic          rst;
  logic          chr_valid, chr_perr, chr_ferr, rd_en, ovr_clr;
  logic [DW-1:0] chr_data;
  logic [1:0]    irq_mode;
  logic          chr_take, chr_hold, rd_perr, rd_ferr, rx_avail, rx_ovr, rx_irq;
  logic [DW-1:0] rd_data;

  always #10 clk = ~clk;

  uart_rx_fifo #(.DEPTH(DEPTH), .DATA_W(DW)) i_uart_rx_fifo (
    .clk(clk), .rst(rst), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_perr(chr_perr), .chr_ferr(chr_ferr), .chr_take(chr_take),
    .chr_hold(chr_hold), .irq_mode(irq_mode), .rd_en(rd_en),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rx_avail(rx_avail), .rx_ovr(rx_ovr), .ovr_clr(ovr_clr), .rx_irq(rx_irq)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference model: entries are {perr, ferr, data}.
  logic [DW+1:0] mq [DEPTH];
  int            mcnt;
  logic          movr;
  logic [DW+1:0] mhead;
  logic          last_take;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq_fn(input logic [1:0] md, input int fill);
    if (md == 2'b10) return fill == DEPTH - 1;
    if (md == 2'b11) return fill == DEPTH;
    return 1'b1;
  endfunction

  task automatic cycle(input logic v, input logic [DW+1:0] c, input logic rd,
                       input logic clr, input logic [1:0] md);
    logic e_take, e_pop, e_irq;
    int   nc;
    string itag;
    @(negedge clk);
    chr_valid = v; {chr_perr, chr_ferr, chr_data} = c;
    rd_en = rd; ovr_clr = clr; irq_mode = md;
    #1;
    e_take = v && (mcnt < DEPTH) && !movr;
    e_pop  = rd && (mcnt > 0);
    chk("R11 take", 32'(chr_take), 32'(e_take));
    chk("R9 hold", 32'(chr_hold), 32'(movr));
    nc    = mcnt + int'(e_take) - int'(e_pop);
    e_irq = e_take && exp_irq_fn(md, nc);
    movr  = !clr && (movr || (v && mcnt == DEPTH));
    if (e_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (e_take) begin
      mq[mcnt] = c;
      mcnt++;
    end
    if (mcnt > 0) mhead = mq[0];
    last_take = e_take;
    itag = (md == 2'b10) ? "R3 irq" : (md == 2'b11) ? "R4 irq" : "R2 irq";
    @(posedge clk);
    #1;
    chk(itag, 32'(rx_irq), 32'(e_irq));
    chk("R5 avail", 32'(rx_avail), 32'(mcnt > 0));
    chk("R8 ovr", 32'(rx_ovr), 32'(movr));
    chk("R7 head", 32'({rd_perr, rd_ferr, rd_data}), 32'(mhead));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; chr_valid = 0; rd_en = 0; ovr_clr = 0; irq_mode = 0;
    chr_data = '0; chr_perr = 0; chr_ferr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mcnt = 0; movr = 0; mhead = '0;
    #1;
    chk("R10 reset avail", 32'(rx_avail), 0);
    chk("R10 reset ovr", 32'(rx_ovr), 0);
    chk("R10 reset irq", 32'(rx_irq), 0);
    chk("R10 reset data", 32'({rd_perr, rd_ferr, rd_data}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic          pv;
    logic [DW+1:0] pc;
    logic [1:0]    md;
    void'($urandom(32'd4711));
    do_reset();

    // R4: mode 11 pulses only when the fourth character lands.
    for (int i = 0; i < DEPTH; i++) cycle(1'b1, 11'h100 + 11'(i), 0, 0, 2'b11);
    // R1: fifth character is not taken; R8 overrun latches.
    cycle(1'b1, 11'h5A5, 0, 0, 2'b11);
    chk("R1 fifth held", 32'(last_take), 0);
    // R9: drain while frozen; held character stays out, contents intact.
    for (int i = 0; i < DEPTH; i++) cycle(1'b1, 11'h5A5, 1, 0, 2'b00);
    chk("R9 held chars drained", 32'(rx_avail), 0);
    // R6: empty read keeps the last character on the outputs.
    cycle(1'b1, 11'h5A5, 1, 0, 2'b00);
    chk("R6 stale data", 32'(rd_data), 32'h103);
    // R10: clear, then the waiting character is taken next cycle.
    cycle(1'b1, 11'h5A5, 0, 1, 2'b00);
    cycle(1'b1, 11'h5A5, 0, 0, 2'b00);
    chk("R10 take after clear", 32'(last_take), 1);
    chk("R7 error flags", 32'({rd_perr, rd_ferr}), 32'h2);
    // R3: mode 10 with a simultaneous read.
    cycle(1'b1, 11'h011, 0, 0, 2'b10);
    cycle(1'b1, 11'h022, 0, 0, 2'b10);
    cycle(1'b1, 11'h033, 1, 0, 2'b10);
    cycle(1'b1, 11'h044, 0, 0, 2'b10);
    // R10: reset empties the buffer.
    do_reset();

    pv = 0; pc = '0; md = 2'b00;
    for (int n = 0; n < 4000; n++) begin
      if (!pv && ($urandom % 3 == 0)) begin pv = 1; pc = 11'($urandom); end
      if ($urandom % 50 == 0) md = 2'($urandom);
      cycle(pv, pc, ($urandom % 4 == 0), (movr && ($urandom % 8 == 0)), md);
      if (last_take) pv = 0;
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule